// File: doc/BRIEF.md
# Serial Frame Receive Status Engine

This block takes a stream of received bits, each qualified by a one-cycle valid strobe, and packs them into bytes. Completed bytes enter a three-entry receive queue that a processor drains through a simple read port. Alongside the data, the block keeps a set of sticky status flags that describe how each frame ended: receive done, CRC error, alignment error, collision/abort and overrun. It also provides a live queue-not-empty indication.

The block supports two framing modes, selected by `mode_idle_i`.

- **Flag-delimited mode.** Frames open and close on the flag octet 0x7E. A run of seven ones aborts the frame.
- **Idle-terminated mode.** A frame begins with its first bit and ends when the line has been quiet for two bit periods. In this mode a collision input is also monitored.

The CRC check is computed outside the block. Its result arrives on `crc_ok_i`, which is sampled at the moment a frame ends.

Top module: `frx_rx_status_engine`

## Requirements
- R1: The queue holds three bytes and returns them oldest first. `rd_data_o` is updated on the clock edge that samples `rd_en_i` high while data is held. A read of an empty queue leaves `rd_data_o` unchanged.
- R2: `stat_nempty_o` is high whenever at least one byte is held. It goes low once software has read every byte.
- R3: A 0-to-1 change of `rx_en_i` empties the queue within two cycles. It also forgets that data entered the queue, for the purpose of collision reporting.
- R4: A byte completed while three bytes are held is discarded and sets `stat_ovr_o`. The flag stays set until it is cleared.
- R5: Bits arrive least significant first. In flag-delimited mode the pattern 0x7E opens a frame and closes it. The bytes between two flags enter the queue in order.
- R6: In idle-terminated mode, a frame ends when no bit strobe has arrived for 2*BIT_CYC cycles, and not before.
- R7: In idle-terminated mode, a partial final byte sets `stat_ae_o` only if `crc_ok_i` is low. With a good CRC, a partial final byte is ignored and the frame counts as done.
- R8: In flag-delimited mode, a closing flag that ends a partial byte sets `stat_ae_o`.
- R9: In flag-delimited mode, seven consecutive ones set `stat_abt_o` only if a byte of the current frame has already entered the queue.
- R10: In idle-terminated mode, a `collision_i` pulse sets `stat_abt_o` if data entered the queue since the last frame start or enable rise. This happens whatever the level of `rx_en_i`; with no such data, the pulse has no effect.
- R11: A frame that ends on a byte boundary with `crc_ok_i` low sets `stat_crce_o`.
- R12: `stat_done_o` is set only by a frame that ends with none of these: CRC error, alignment error, abort/collision or overrun.
- R13: The five error and done flags are sticky and are cleared only by writing one to their bit of `clr_i`. The bit map is: [0] done, [1] CRC, [2] alignment, [3] abort, [4] overrun. Reset clears all flags, and a new frame start leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_idle_i | input | 1 | 1 = idle-terminated framing, 0 = flag-delimited framing |
| rx_en_i | input | 1 | Receive enable; a rising edge flushes the queue |
| bit_vld_i | input | 1 | Strobe marking a received bit |
| bit_val_i | input | 1 | Received bit value |
| collision_i | input | 1 | Collision indication (idle-terminated mode) |
| crc_ok_i | input | 1 | External CRC verdict, sampled at end of frame |
| rd_en_i | input | 1 | Pop one byte from the queue |
| rd_data_o | output | 8 | Byte returned by the last pop |
| clr_i | input | 5 | Write-one-to-clear strobes for the sticky flags |
| stat_nempty_o | output | 1 | Queue holds data |
| stat_done_o | output | 1 | Error-free frame completed |
| stat_crce_o | output | 1 | CRC error on a byte-aligned frame |
| stat_ae_o | output | 1 | Alignment error |
| stat_abt_o | output | 1 | Abort or collision after data |
| stat_ovr_o | output | 1 | Queue overrun |

## Verification
The bench drives clean byte-aligned frames in both modes, so that a good ending yields done and a queue that reads back in order. It then varies one factor at a time:

- **Trailing partial bits.** Three extra bits before the end separate the two alignment rules. In flag mode they always raise an alignment error; in idle mode they do so only when the CRC is bad.
- **Ones runs.** Seven ones placed after two bytes must report an abort, while the same run right after an opening flag must not. This distinguishes the "data has entered" condition from a simple abort detector.
- **Queue limits.** A four-byte frame, an enable toggle and collision pulses, with and without prior data, exercise overrun, flush and the enable-independent collision rule.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;

  localparam int CLR_DONE = 0;
  localparam int CLR_CRCE = 1;
  localparam int CLR_AE   = 2;
  localparam int CLR_ABT  = 3;
  localparam int CLR_OVR  = 4;
  localparam int CLR_W    = 5;

  typedef struct packed {
    logic vld;
    logic partial;
    logic crc_ok;
    logic idle;
  } eof_t;
endpackage

// File: rtl/frx_bit_front.sv
module frx_bit_front
  import frx_pkg::*;
#(
  parameter int BIT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              mode_idle_i,
  input  logic              rx_en_i,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              collision_i,
  input  logic              crc_ok_i,
  output logic              push_vld_o,
  output logic [BYTE_W-1:0] push_byte_o,
  output eof_t              eof_o,
  output logic              abt_o,
  output logic              start_o,
  output logic              flush_o
);
  localparam int IDLE_LIM = 2 * BIT_CYC;
  localparam int IW = $clog2(IDLE_LIM + 1);

  logic [7:0]        hist_q, hist_d;
  logic [3:0]        hcnt_q, hcnt_d;
  logic [2:0]        ones_q, ones_d;
  logic              inf_q, inf_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic              fed_q, fed_d;
  logic              got_q, got_d;
  logic [IW-1:0]     idle_q, idle_d;
  logic              en_q;

  logic              push_d, abt_d, start_d, flush_d;
  logic [BYTE_W-1:0] pbyte_d;
  eof_t              eof_d;
  logic              do_feed, fbit;
  logic [7:0]        win;

  always_comb begin
    hist_d  = hist_q;
    hcnt_d  = hcnt_q;
    ones_d  = ones_q;
    inf_d   = inf_q;
    sh_d    = sh_q;
    bcnt_d  = bcnt_q;
    fed_d   = fed_q;
    got_d   = got_q;
    idle_d  = idle_q;
    push_d  = 1'b0;
    pbyte_d = push_byte_o;
    abt_d   = 1'b0;
    start_d = 1'b0;
    flush_d = rx_en_i && !en_q;
    eof_d   = '0;
    do_feed = 1'b0;
    fbit    = 1'b0;
    win     = {hist_q[6:0], bit_val_i};

    if (!rx_en_i) begin
      inf_d  = 1'b0;
      hcnt_d = '0;
      ones_d = '0;
      bcnt_d = '0;
      fed_d  = 1'b0;
      idle_d = '0;
    end else if (bit_vld_i) begin
      if (mode_idle_i) begin
        idle_d = '0;
        if (!inf_q) begin
          inf_d   = 1'b1;
          start_d = 1'b1;
          got_d   = 1'b0;
        end
        do_feed = 1'b1;
        fbit    = bit_val_i;
      end else begin
        hist_d  = win;
        hcnt_d  = (hcnt_q == 4'd8) ? 4'd8 : hcnt_q + 4'd1;
        ones_d  = !bit_val_i ? 3'd0 : ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1);
        do_feed = inf_q && (hcnt_q == 4'd8);
        fbit    = hist_q[7];
      end
    end else if (mode_idle_i && inf_q) begin
      if (idle_q == IW'(IDLE_LIM - 1)) begin
        eof_d.vld     = 1'b1;
        eof_d.partial = (bcnt_q != 3'd0);
        eof_d.crc_ok  = crc_ok_i;
        eof_d.idle    = 1'b1;
        inf_d         = 1'b0;
        bcnt_d        = '0;
        idle_d        = '0;
      end else begin
        idle_d = idle_q + IW'(1);
      end
    end

    // byte assembly, least significant bit first
    if (do_feed) begin
      sh_d  = {fbit, sh_q[BYTE_W-1:1]};
      fed_d = 1'b1;
      if (bcnt_q == 3'd7) begin
        push_d  = 1'b1;
        pbyte_d = sh_d;
        bcnt_d  = '0;
        got_d   = 1'b1;
      end else begin
        bcnt_d = bcnt_q + 3'd1;
      end
    end

    // flag-mode framing events: abort takes precedence over flag match
    if (rx_en_i && bit_vld_i && !mode_idle_i) begin
      if (bit_val_i && ones_q == 3'd6) begin
        abt_d  = inf_q && got_d;
        inf_d  = 1'b0;
        hcnt_d = '0;
        bcnt_d = '0;
        fed_d  = 1'b0;
      end else if (hcnt_q >= 4'd7 && win == FLAG_PAT) begin
        if (inf_q && fed_d) begin
          eof_d.vld     = 1'b1;
          eof_d.partial = (bcnt_d != 3'd0);
          eof_d.crc_ok  = crc_ok_i;
          eof_d.idle    = 1'b0;
        end
        inf_d   = 1'b1;
        start_d = 1'b1;
        hcnt_d  = '0;
        bcnt_d  = '0;
        fed_d   = 1'b0;
        got_d   = 1'b0;
      end
    end

    // collision monitoring runs regardless of the enable
    if (mode_idle_i && collision_i && got_q) abt_d = 1'b1;
    if (flush_d) got_d = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q      <= '0;
      hcnt_q      <= '0;
      ones_q      <= '0;
      inf_q       <= 1'b0;
      sh_q        <= '0;
      bcnt_q      <= '0;
      fed_q       <= 1'b0;
      got_q       <= 1'b0;
      idle_q      <= '0;
      en_q        <= 1'b0;
      push_vld_o  <= 1'b0;
      push_byte_o <= '0;
      eof_o       <= '0;
      abt_o       <= 1'b0;
      start_o     <= 1'b0;
      flush_o     <= 1'b0;
    end else begin
      hist_q      <= hist_d;
      hcnt_q      <= hcnt_d;
      ones_q      <= ones_d;
      inf_q       <= inf_d;
      sh_q        <= sh_d;
      bcnt_q      <= bcnt_d;
      fed_q       <= fed_d;
      got_q       <= got_d;
      idle_q      <= idle_d;
      en_q        <= rx_en_i;
      push_vld_o  <= push_d;
      push_byte_o <= pbyte_d;
      eof_o       <= eof_d;
      abt_o       <= abt_d;
      start_o     <= start_d;
      flush_o     <= flush_d;
    end
  end
endmodule

// File: rtl/frx_rx_fifo.sv
module frx_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic         wr_ok_o,
  output logic         nempty_o,
  output logic [W-1:0] rd_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_fire, rd_fire;

  assign wr_ok_o  = (cnt_q != CW'(DEPTH));
  assign nempty_o = (cnt_q != '0);
  assign wr_fire  = wr_i && wr_ok_o && !flush_i;
  assign rd_fire  = rd_i && nempty_o && !flush_i;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_fire) wptr_q <= bump(wptr_q);
      if (rd_fire) rptr_q <= bump(rptr_q);
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rd_data_o <= '0;
    else if (rd_fire) rd_data_o <= mem[rptr_q];
  end
endmodule

// File: rtl/frx_status_regs.sv
module frx_status_regs
  import frx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  eof_t              eof_i,
  input  logic              abt_i,
  input  logic              ovr_i,
  input  logic              start_i,
  input  logic [CLR_W-1:0]  clr_i,
  output logic              done_o,
  output logic              crce_o,
  output logic              ae_o,
  output logic              abt_o,
  output logic              ovr_o
);
  logic frm_abt_q, frm_ovr_q;
  logic bad_frm, set_done, set_crce, set_ae;

  always_comb begin
    bad_frm  = frm_abt_q || abt_i || frm_ovr_q || ovr_i;
    set_crce = eof_i.vld && !eof_i.partial && !eof_i.crc_ok;
    set_ae   = eof_i.vld && eof_i.partial && (eof_i.idle ? !eof_i.crc_ok : 1'b1);
    set_done = eof_i.vld && eof_i.crc_ok && !(eof_i.partial && !eof_i.idle) && !bad_frm;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frm_abt_q <= 1'b0;
      frm_ovr_q <= 1'b0;
      done_o    <= 1'b0;
      crce_o    <= 1'b0;
      ae_o      <= 1'b0;
      abt_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      frm_abt_q <= start_i ? 1'b0 : (frm_abt_q || abt_i);
      frm_ovr_q <= start_i ? 1'b0 : (frm_ovr_q || ovr_i);
      done_o    <= (done_o && !clr_i[CLR_DONE]) || set_done;
      crce_o    <= (crce_o && !clr_i[CLR_CRCE]) || set_crce;
      ae_o      <= (ae_o   && !clr_i[CLR_AE])   || set_ae;
      abt_o     <= (abt_o  && !clr_i[CLR_ABT])  || abt_i;
      ovr_o     <= (ovr_o  && !clr_i[CLR_OVR])  || ovr_i;
    end
  end
endmodule

// File: rtl/frx_rx_status_engine.sv
module frx_rx_status_engine
  import frx_pkg::*;
#(
  parameter int BIT_CYC    = 4,
  parameter int FIFO_DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              mode_idle_i,
  input  logic              rx_en_i,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              collision_i,
  input  logic              crc_ok_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [CLR_W-1:0]  clr_i,
  output logic              stat_nempty_o,
  output logic              stat_done_o,
  output logic              stat_crce_o,
  output logic              stat_ae_o,
  output logic              stat_abt_o,
  output logic              stat_ovr_o
);
  logic              push_vld, abt_ev, start_ev, flush_ev, wr_ok;
  logic [BYTE_W-1:0] push_byte;
  eof_t              eof_ev;

  frx_bit_front #(.BIT_CYC(BIT_CYC)) front_i (
    .clk_i(clk_i), .rst_i(rst_i), .mode_idle_i(mode_idle_i), .rx_en_i(rx_en_i),
    .bit_vld_i(bit_vld_i), .bit_val_i(bit_val_i), .collision_i(collision_i),
    .crc_ok_i(crc_ok_i), .push_vld_o(push_vld), .push_byte_o(push_byte),
    .eof_o(eof_ev), .abt_o(abt_ev), .start_o(start_ev), .flush_o(flush_ev)
  );

  frx_rx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(flush_ev), .wr_i(push_vld),
    .wr_data_i(push_byte), .rd_i(rd_en_i), .wr_ok_o(wr_ok),
    .nempty_o(stat_nempty_o), .rd_data_o(rd_data_o)
  );

  frx_status_regs stat_i (
    .clk_i(clk_i), .rst_i(rst_i), .eof_i(eof_ev), .abt_i(abt_ev),
    .ovr_i(push_vld && !wr_ok), .start_i(start_ev), .clr_i(clr_i),
    .done_o(stat_done_o), .crce_o(stat_crce_o), .ae_o(stat_ae_o),
    .abt_o(stat_abt_o), .ovr_o(stat_ovr_o)
  );
endmodule

// File: rtl/frx_rx_status_engine_chk.sv
module frx_rx_status_engine_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       rx_en_i,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o,
  input logic [4:0] clr_i,
  input logic       stat_nempty_o,
  input logic       stat_done_o,
  input logic       stat_crce_o,
  input logic       stat_ae_o,
  input logic       stat_ovr_o
);
  // R1: popping an empty queue leaves the read data alone
  p_read_empty_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stat_nempty_o && rd_en_i) |=> $stable(rd_data_o));

  // R3: enable rise empties the queue two samples later
  p_flush_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_en_i) |=> ##1 !stat_nempty_o);

  // R4: overrun can only appear while the queue held data
  p_ovr_full_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(stat_ovr_o) |-> $past(stat_nempty_o));

  // R12: done never rises together with a CRC or alignment error
  p_done_excl_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(stat_done_o) |-> (!$rose(stat_crce_o) && !$rose(stat_ae_o)));

  // R13: sticky flags drop only after their clear strobe
  p_sticky_ovr_r13: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_ovr_o && !clr_i[4]) |=> stat_ovr_o);
  p_sticky_done_r13: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_done_o && !clr_i[0]) |=> stat_done_o);
endmodule

bind frx_rx_status_engine frx_rx_status_engine_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .rx_en_i(rx_en_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .clr_i(clr_i), .stat_nempty_o(stat_nempty_o),
  .stat_done_o(stat_done_o), .stat_crce_o(stat_crce_o), .stat_ae_o(stat_ae_o),
  .stat_ovr_o(stat_ovr_o)
);

// File: tb/frx_rx_status_engine_tb_top.sv
`timescale 1ns/1ps
module frx_rx_status_engine_tb_top;
  localparam int BIT_CYC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_idle = 1'b0, rx_en = 1'b0, bit_vld = 1'b0, bit_val = 1'b0;
  logic       collision = 1'b0, crc_ok = 1'b1, rd_en = 1'b0;
  logic [4:0] clr = '0;
  logic [7:0] rd_data;
  logic       nempty, done, crce, ae, abt, ovr;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  frx_rx_status_engine #(.BIT_CYC(BIT_CYC), .FIFO_DEPTH(3)) dut_i (
    .clk_i(clk), .rst_i(rst), .mode_idle_i(mode_idle), .rx_en_i(rx_en),
    .bit_vld_i(bit_vld), .bit_val_i(bit_val), .collision_i(collision),
    .crc_ok_i(crc_ok), .rd_en_i(rd_en), .rd_data_o(rd_data), .clr_i(clr),
    .stat_nempty_o(nempty), .stat_done_o(done), .stat_crce_o(crce),
    .stat_ae_o(ae), .stat_abt_o(abt), .stat_ovr_o(ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_vld = 1'b1; bit_val = b;
    @(negedge clk); bit_vld = 1'b0;
    repeat (BIT_CYC - 2) @(negedge clk);
  endtask

  // driver: sends a byte LSB first, optionally queueing it as expected data
  task automatic send_byte(input logic [7:0] v, input bit expect_it);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    if (expect_it) exp_q.push_back(v);
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit(i != 0 && i != 7);
  endtask

  task automatic read_one();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 5'h1F;
    @(negedge clk); clr = '0;
  endtask

  // monitor: every accepted pop is compared with the oldest expected byte (R1)
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        @(negedge clk);
        check("R1 read order", rd_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog (all requirements) actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    check("R13 reset done", done, 0);
    check("R13 reset errors", {crce, ae, abt, ovr}, 0);
    check("R2 reset empty", nempty, 0);
    rx_en = 1'b1;

    // R5 / R12: clean flag-delimited frame
    send_flag(); send_byte(8'h12, 1); send_byte(8'h34, 1); send_flag();
    wait_n(3);
    check("R12 done clean", done, 1);
    check("R5 no errors", {crce, ae, abt, ovr}, 0);
    check("R2 nonempty", nempty, 1);
    read_one(); read_one(); wait_n(1);
    check("R2 empty after reads", nempty, 0);
    read_one(); wait_n(1);
    check("R1 empty read keeps data", rd_data, 8'h34);
    clear_all();

    // R11: aligned frame with bad CRC
    crc_ok = 1'b0;
    send_flag(); send_byte(8'h05, 1); send_flag(); wait_n(3);
    check("R11 crc error", crce, 1);
    check("R12 no done on crc", done, 0);
    check("R11 no ae", ae, 0);
    read_one(); clear_all(); crc_ok = 1'b1;

    // R8: misaligned closing flag
    send_flag(); send_byte(8'h12, 1);
    send_bit(0); send_bit(0); send_bit(1); send_flag(); wait_n(3);
    check("R8 alignment error", ae, 1);
    check("R12 no done on ae", done, 0);
    read_one(); clear_all();

    // R9: abort after data entered the queue
    send_flag(); send_byte(8'h12, 1); send_byte(8'h34, 0);
    for (int i = 0; i < 7; i++) send_bit(1);
    wait_n(3);
    check("R9 abort after data", abt, 1);
    check("R12 no done on abort", done, 0);
    read_one(); clear_all();
    send_flag();
    for (int i = 0; i < 7; i++) send_bit(1);
    wait_n(3);
    check("R9 abort without data ignored", abt, 0);
    check("R9 queue empty", nempty, 0);

    // R4: four bytes into a three-byte queue
    send_flag(); send_byte(8'h01, 1); send_byte(8'h02, 1); send_byte(8'h03, 1);
    send_byte(8'h04, 0); send_flag(); wait_n(3);
    check("R4 overrun", ovr, 1);
    check("R12 no done on overrun", done, 0);
    read_one(); read_one(); read_one(); wait_n(1);
    check("R4 overrun sticky after reads", ovr, 1);
    send_flag(); wait_n(3);
    check("R13 frame start keeps flag", ovr, 1);
    @(negedge clk); clr = 5'h01; @(negedge clk); clr = '0; wait_n(1);
    check("R13 other clear keeps ovr", ovr, 1);
    @(negedge clk); clr = 5'h10; @(negedge clk); clr = '0; wait_n(1);
    check("R13 w1c clears ovr", ovr, 0);

    // R3: flush on enable rise
    send_flag(); send_byte(8'h12, 1); send_byte(8'h34, 1); send_flag(); wait_n(3);
    check("R3 data present", nempty, 1);
    @(negedge clk); rx_en = 1'b0; wait_n(2); rx_en = 1'b1; exp_q.delete(); wait_n(3);
    check("R3 flushed", nempty, 0);
    clear_all();

    // idle-terminated mode
    @(negedge clk); rx_en = 1'b0; mode_idle = 1'b1; wait_n(2); rx_en = 1'b1; wait_n(2);

    send_byte(8'h12, 1); send_byte(8'h34, 1);
    check("R6 frame still open", done, 0);
    wait_n(2 * BIT_CYC + 4);
    check("R6 done after idle", done, 1);
    read_one(); read_one(); clear_all();

    send_byte(8'h05, 1); send_bit(1); send_bit(0); send_bit(1);
    wait_n(2 * BIT_CYC + 4);
    check("R7 partial good crc no ae", ae, 0);
    check("R7 partial good crc done", done, 1);
    read_one(); clear_all();

    crc_ok = 1'b0;
    send_byte(8'h05, 1); send_bit(1); send_bit(0); send_bit(1);
    wait_n(2 * BIT_CYC + 4);
    check("R7 partial bad crc ae", ae, 1);
    check("R7 partial bad crc no crce", crce, 0);
    check("R12 no done", done, 0);
    read_one(); clear_all();

    send_byte(8'h05, 1); wait_n(2 * BIT_CYC + 4);
    check("R11 idle crc error", crce, 1);
    check("R11 idle no ae", ae, 0);
    read_one(); clear_all(); crc_ok = 1'b1;

    // R10: collision with enable low after data
    send_byte(8'h12, 0); wait_n(2 * BIT_CYC + 4);
    clear_all();
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); collision = 1'b1; @(negedge clk); collision = 1'b0; wait_n(3);
    check("R10 collision with enable low", abt, 1);
    clear_all();
    @(negedge clk); rx_en = 1'b1; wait_n(3);
    @(negedge clk); collision = 1'b1; @(negedge clk); collision = 1'b0; wait_n(3);
    check("R10 collision without data ignored", abt, 0);
    check("R3 flush emptied queue", nempty, 0);

    wait_n(3);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule